// File: doc/BRIEF.md
# Variable-Length Execute Packet Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue processor. Fetch delivers aligned 512-bit fetch packets. Inside them, 16-bit and 32-bit instructions are packed with no padding. The dispatcher keeps a window of 16-bit parcels and reads the length and parallel flags of each instruction to find where an execute packet ends. It then issues the whole packet in one cycle. Instruction k of the packet goes to functional-unit slot k, and the byte address of the packet's first parcel is reported with it.

Because nothing is padded, a packet can start near the end of one fetch packet and finish in the next one. The window keeps the unused tail of a fetch packet and asks for the next fetch packet whenever the parcels it holds do not yet form a complete execute packet. A global stall freezes the block. A flush drops every buffered parcel and restarts extraction at a supplied parcel-aligned byte address, which need not be at the start of a fetch packet.

Top module: `ep_dispatch`

## Requirements
- R1: While reset is asserted, disp_valid is low, slot_valid is all zero, every slot_inst field is zero, fetch_addr equals RESET_PC aligned down to 64 bytes, and fetch_req is high when stall is low.
- R2: Instruction encoding:
  - Bit 0 of the first parcel of an instruction is the length flag (1 means 32-bit, 0 means 16-bit).
  - Bit 1 of that parcel is the parallel flag (1 means the next instruction is in the same packet).
  - A 32-bit instruction leaves in its slot as {second parcel, first parcel}.
  - A 16-bit instruction leaves zero-extended.
  - Within a fetch packet, parcel j occupies fp_data bits [16j+15:16j].
- R3: The k-th instruction of a packet drives slot k, whose 32-bit field is slot_inst[32k+31:32k]. slot_valid is a contiguous run of ones starting at bit 0. Slots with no instruction carry zero and a low valid bit. disp_valid equals slot_valid[0].
- R4: disp_pc is the byte address of the first parcel of the dispatched packet.
- R5: A packet whose parcels lie in two fetch packets is dispatched whole, in a single cycle.
- R6: A packet holds at most eleven instructions. The eleventh instruction ends the packet even when its parallel flag is set.
- R7: fetch_req is high exactly when stall is low and the buffered parcels do not contain a complete packet. A fetch packet is accepted on a clock edge with fetch_req and fp_valid high, and fetch_addr then advances by 64. Otherwise fetch_addr is unchanged, except on flush.
- R8: While stall is high and flush is low, fetch_req is low and all outputs and buffered state hold.
- R9: flush (which takes priority over stall) has three effects on the next edge:
  - disp_valid and slot_valid are cleared.
  - fetch_addr is set to flush_pc aligned down to 64 bytes.
  - Extraction restarts at flush_pc, skipping the leading parcels of the first fetched packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global stall: freeze state and outputs |
| flush | input | 1 | Discard buffered parcels and restart at flush_pc |
| flush_pc | input | PC_W | Restart byte address (parcel aligned) |
| fetch_req | output | 1 | Request for the next fetch packet |
| fetch_addr | output | PC_W | 64-byte aligned address of the requested fetch packet |
| fp_valid | input | 1 | fp_data holds the requested fetch packet |
| fp_data | input | FP_W | Fetch packet, parcel 0 in the low bits |
| disp_valid | output | 1 | A packet is dispatched this cycle |
| disp_pc | output | PC_W | Byte address of the dispatched packet |
| slot_valid | output | NUM_SLOTS | Per-slot instruction valid |
| slot_inst | output | NUM_SLOTS*2*PARCEL_W | Per-slot instruction, slot k at bits [32k+31:32k] |

## Verification
A fetch packet presented with fetch_req high is written into the window at that edge. A packet it completes is dispatched at the following edge, so the dispatch outputs show it two edges after the data was driven. The fetch_addr step appears one edge after acceptance, and the effect of a flush is also due one edge after it is driven.

The bench drives every input at the falling edge and reads every output at the next falling edge. At that point it compares each result against what the previous edge's inputs imply. It counts a new dispatch only when the edge before it was not stalled, and it checks that outputs are unchanged after a stalled edge. In this way each packet is compared once against a list of expected packets, which the bench builds from its own program generator in dispatch order.

// File: rtl/ep_dispatch_pkg.sv
package ep_dispatch_pkg;
  // Position of the flags inside the first parcel of every instruction.
  localparam int LEN_BIT = 0;  // 1: 32-bit instruction (two parcels)
  localparam int PAR_BIT = 1;  // 1: next instruction issues with this one
endpackage

// File: rtl/ep_len_decode.sv
module ep_len_decode
  import ep_dispatch_pkg::*;
#(
  parameter int PARCEL_W  = 16,
  parameter int NUM_SLOTS = 11,
  parameter int CNT_W     = 6
) (
  input  logic [2*NUM_SLOTS*PARCEL_W-1:0]   head,
  input  logic [CNT_W-1:0]                  count,
  output logic                              complete,
  output logic [CNT_W-1:0]                  used,
  output logic [NUM_SLOTS-1:0]              valid,
  output logic [NUM_SLOTS*2*PARCEL_W-1:0]   insts
);
  timeunit 1ns; timeprecision 1ps;

  localparam int INST_W = 2 * PARCEL_W;

  // Walk the head of the window one instruction at a time until the
  // parallel chain ends, the slot limit is reached or parcels run out.
  always_comb begin
    int  pos;
    int  w;
    logic stop;
    logic wide;
    logic par;
    complete = 1'b0;
    valid    = '0;
    insts    = '0;
    pos      = 0;
    stop     = 1'b0;
    wide     = 1'b0;
    par      = 1'b0;
    w        = 1;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (!stop) begin
        if (pos >= int'(count)) begin
          stop = 1'b1;
        end else begin
          wide = head[pos*PARCEL_W + LEN_BIT];
          par  = head[pos*PARCEL_W + PAR_BIT];
          w    = wide ? 2 : 1;
          if (pos + w > int'(count)) begin
            stop = 1'b1;
          end else begin
            if (wide)
              insts[k*INST_W +: INST_W] = head[pos*PARCEL_W +: INST_W];
            else
              insts[k*INST_W +: INST_W] = {{PARCEL_W{1'b0}}, head[pos*PARCEL_W +: PARCEL_W]};
            valid[k] = 1'b1;
            pos      = pos + w;
            if (!par || k == NUM_SLOTS - 1) begin
              stop     = 1'b1;
              complete = 1'b1;
            end
          end
        end
      end
    end
    used = CNT_W'(pos);
  end
endmodule

// File: rtl/ep_parcel_window.sv
module ep_parcel_window #(
  parameter int              FP_W      = 512,
  parameter int              PARCEL_W  = 16,
  parameter int              NUM_SLOTS = 11,
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_PC  = '0,
  parameter int              CNT_W     = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            hold,
  input  logic                            flush,
  input  logic [PC_W-1:0]                 flush_pc,
  input  logic                            consume,
  input  logic [CNT_W-1:0]                used,
  input  logic                            accept,
  input  logic [FP_W-1:0]                 fp_data,
  output logic [2*NUM_SLOTS*PARCEL_W-1:0] head,
  output logic [CNT_W-1:0]                count,
  output logic [PC_W-1:0]                 head_pc,
  output logic [PC_W-1:0]                 fetch_addr
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PPF          = FP_W / PARCEL_W;
  localparam int DEC_P        = 2 * NUM_SLOTS;
  localparam int BUF          = PPF + DEC_P;
  localparam int FP_BYTES     = FP_W / 8;
  localparam int PARCEL_BYTES = PARCEL_W / 8;
  localparam int FB_LSB       = $clog2(FP_BYTES);
  localparam int PB_LSB       = $clog2(PARCEL_BYTES);
  localparam int OFF_W        = FB_LSB - PB_LSB;

  logic [PARCEL_W-1:0] buf_q [BUF];
  logic [CNT_W-1:0]    cnt_q;
  logic [OFF_W-1:0]    skip_q;
  logic [PC_W-1:0]     pc_q;
  logic [PC_W-1:0]     fa_q;

  function automatic logic [PC_W-1:0] fp_base(input logic [PC_W-1:0] a);
    return a & ~PC_W'(FP_BYTES - 1);
  endfunction

  function automatic logic [PC_W-1:0] parcel_base(input logic [PC_W-1:0] a);
    return a & ~PC_W'(PARCEL_BYTES - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      skip_q <= RESET_PC[FB_LSB-1:PB_LSB];
      pc_q   <= parcel_base(RESET_PC);
      fa_q   <= fp_base(RESET_PC);
    end else if (flush) begin
      cnt_q  <= '0;
      skip_q <= flush_pc[FB_LSB-1:PB_LSB];
      pc_q   <= parcel_base(flush_pc);
      fa_q   <= fp_base(flush_pc);
    end else if (!hold) begin
      if (consume) begin
        // Retire the dispatched packet: slide the window toward parcel 0.
        for (int i = 0; i < BUF; i++) begin
          if (i + int'(used) < BUF)
            buf_q[i] <= buf_q[i + int'(used)];
        end
        cnt_q <= cnt_q - used;
        pc_q  <= pc_q + (PC_W'(used) << PB_LSB);
      end else if (accept) begin
        // Append the new fetch packet behind the held tail.
        for (int j = 0; j < PPF; j++) begin
          if (j >= int'(skip_q) && (int'(cnt_q) + j - int'(skip_q)) < BUF)
            buf_q[int'(cnt_q) + j - int'(skip_q)] <= fp_data[j*PARCEL_W +: PARCEL_W];
        end
        cnt_q  <= cnt_q + CNT_W'(PPF) - CNT_W'(skip_q);
        skip_q <= '0;
        fa_q   <= fa_q + PC_W'(FP_BYTES);
      end
    end
  end

  for (genvar g = 0; g < DEC_P; g++) begin : g_head
    assign head[g*PARCEL_W +: PARCEL_W] = buf_q[g];
  end

  assign count      = cnt_q;
  assign head_pc    = pc_q;
  assign fetch_addr = fa_q;
endmodule

// File: rtl/ep_issue_reg.sv
module ep_issue_reg #(
  parameter int PARCEL_W  = 16,
  parameter int NUM_SLOTS = 11,
  parameter int PC_W      = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            hold,
  input  logic                            flush,
  input  logic                            load,
  input  logic [PC_W-1:0]                 pc_in,
  input  logic [NUM_SLOTS-1:0]            valid_in,
  input  logic [NUM_SLOTS*2*PARCEL_W-1:0] insts_in,
  output logic                            disp_valid,
  output logic [PC_W-1:0]                 disp_pc,
  output logic [NUM_SLOTS-1:0]            slot_valid,
  output logic [NUM_SLOTS*2*PARCEL_W-1:0] slot_inst
);
  timeunit 1ns; timeprecision 1ps;

  localparam int INST_W = 2 * PARCEL_W;

  logic            dv_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q <= 1'b0;
      pc_q <= '0;
    end else if (flush) begin
      dv_q <= 1'b0;
    end else if (!hold) begin
      dv_q <= load;
      if (load) pc_q <= pc_in;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic              v_q;
    logic [INST_W-1:0] i_q;
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        v_q <= 1'b0;
        i_q <= '0;
      end else if (!hold) begin
        v_q <= load & valid_in[g];
        i_q <= load ? insts_in[g*INST_W +: INST_W] : '0;
      end
    end
    assign slot_valid[g]                 = v_q;
    assign slot_inst[g*INST_W +: INST_W] = i_q;
  end

  assign disp_valid = dv_q;
  assign disp_pc    = pc_q;
endmodule

// File: rtl/ep_dispatch.sv
module ep_dispatch #(
  parameter int              FP_W      = 512,
  parameter int              PARCEL_W  = 16,
  parameter int              NUM_SLOTS = 11,
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_PC  = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            stall,
  input  logic                            flush,
  input  logic [PC_W-1:0]                 flush_pc,
  output logic                            fetch_req,
  output logic [PC_W-1:0]                 fetch_addr,
  input  logic                            fp_valid,
  input  logic [FP_W-1:0]                 fp_data,
  output logic                            disp_valid,
  output logic [PC_W-1:0]                 disp_pc,
  output logic [NUM_SLOTS-1:0]            slot_valid,
  output logic [NUM_SLOTS*2*PARCEL_W-1:0] slot_inst
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PPF    = FP_W / PARCEL_W;
  localparam int DEC_P  = 2 * NUM_SLOTS;
  localparam int BUF    = PPF + DEC_P;
  localparam int CNT_W  = $clog2(BUF + 1);
  localparam int INST_W = 2 * PARCEL_W;

  logic [DEC_P*PARCEL_W-1:0]   head;
  logic [CNT_W-1:0]            count;
  logic [PC_W-1:0]             head_pc;
  logic                        complete;
  logic [CNT_W-1:0]            used;
  logic [NUM_SLOTS-1:0]        dec_valid;
  logic [NUM_SLOTS*INST_W-1:0] dec_insts;
  logic                        consume;
  logic                        accept;

  assign fetch_req = !complete && !stall;
  assign accept    = fetch_req && fp_valid;
  assign consume   = complete && !stall;

  ep_parcel_window #(
    .FP_W(FP_W), .PARCEL_W(PARCEL_W), .NUM_SLOTS(NUM_SLOTS),
    .PC_W(PC_W), .RESET_PC(RESET_PC), .CNT_W(CNT_W)
  ) u_window (
    .clk(clk), .rst(rst), .hold(stall), .flush(flush), .flush_pc(flush_pc),
    .consume(consume), .used(used), .accept(accept), .fp_data(fp_data),
    .head(head), .count(count), .head_pc(head_pc), .fetch_addr(fetch_addr)
  );

  ep_len_decode #(
    .PARCEL_W(PARCEL_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_decode (
    .head(head), .count(count), .complete(complete), .used(used),
    .valid(dec_valid), .insts(dec_insts)
  );

  ep_issue_reg #(
    .PARCEL_W(PARCEL_W), .NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W)
  ) u_issue (
    .clk(clk), .rst(rst), .hold(stall), .flush(flush), .load(complete),
    .pc_in(head_pc), .valid_in(dec_valid), .insts_in(dec_insts),
    .disp_valid(disp_valid), .disp_pc(disp_pc),
    .slot_valid(slot_valid), .slot_inst(slot_inst)
  );
endmodule

// File: rtl/ep_dispatch_checker.sv
module ep_dispatch_checker #(
  parameter int FP_W      = 512,
  parameter int PARCEL_W  = 16,
  parameter int NUM_SLOTS = 11,
  parameter int PC_W      = 32
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            stall,
  input logic                            flush,
  input logic [PC_W-1:0]                 flush_pc,
  input logic                            fetch_req,
  input logic [PC_W-1:0]                 fetch_addr,
  input logic                            fp_valid,
  input logic                            disp_valid,
  input logic [PC_W-1:0]                 disp_pc,
  input logic [NUM_SLOTS-1:0]            slot_valid,
  input logic [NUM_SLOTS*2*PARCEL_W-1:0] slot_inst
);
  timeunit 1ns; timeprecision 1ps;

  localparam int INST_W   = 2 * PARCEL_W;
  localparam int FP_BYTES = FP_W / 8;

  logic nop_ok;
  always_comb begin
    nop_ok = 1'b1;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (!slot_valid[k] && slot_inst[k*INST_W +: INST_W] != '0) nop_ok = 1'b0;
  end

  p_nop_zero_r3: assert property (@(posedge clk) disable iff (rst) nop_ok);

  p_slot_contig_r3: assert property (@(posedge clk) disable iff (rst)
    ((slot_valid & (slot_valid + 1'b1)) == '0) && (disp_valid == slot_valid[0]));

  p_stall_noreq_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> !fetch_req);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(disp_pc) && $stable(disp_valid) &&
                           $stable(slot_valid) && $stable(slot_inst) && $stable(fetch_addr)));

  p_flush_restart_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!disp_valid && slot_valid == '0 &&
               fetch_addr == ($past(flush_pc) & ~PC_W'(FP_BYTES - 1))));

  p_fetch_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fp_valid && !flush) |=> fetch_addr == $past(fetch_addr) + PC_W'(FP_BYTES));

  p_fetch_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!flush && !(fetch_req && fp_valid)) |=> $stable(fetch_addr));
endmodule

bind ep_dispatch ep_dispatch_checker #(
  .FP_W(FP_W), .PARCEL_W(PARCEL_W), .NUM_SLOTS(NUM_SLOTS), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .flush(flush), .flush_pc(flush_pc),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fp_valid(fp_valid),
  .disp_valid(disp_valid), .disp_pc(disp_pc),
  .slot_valid(slot_valid), .slot_inst(slot_inst)
);

// File: tb/sim_ep_dispatch.sv
module sim_ep_dispatch;
  timeunit 1ns; timeprecision 1ps;

  localparam int FP_W = 512;
  localparam int NS   = 11;
  localparam int PPF  = 32;
  localparam int MEMP = 4096;
  localparam int NPK  = 200;
  localparam int SW   = NS * 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, stall = 1'b0, flush = 1'b0, fp_valid = 1'b0;
  logic [31:0]   flush_pc = '0;
  logic [FP_W-1:0] fp_data = '0;
  logic          fetch_req, disp_valid;
  logic [31:0]   fetch_addr, disp_pc;
  logic [NS-1:0] slot_valid;
  logic [SW-1:0] slot_inst;

  ep_dispatch u0 (
    .clk(clk), .rst(rst), .stall(stall), .flush(flush), .flush_pc(flush_pc),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fp_valid(fp_valid),
    .fp_data(fp_data), .disp_valid(disp_valid), .disp_pc(disp_pc),
    .slot_valid(slot_valid), .slot_inst(slot_inst)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] prog  [MEMP];
  logic [31:0] e_pc  [NPK];
  int          e_n   [NPK];
  logic [31:0] e_ins [NPK][NS];
  bit          e_str [NPK];

  int idx = 0;
  bit prev_stall = 0, prev_flush = 0, prev_acc = 0;
  logic [31:0] prev_fa = '0, flush_tgt = '0;
  logic          sn_dv;
  logic [31:0]   sn_pc;
  logic [NS-1:0] sn_sv;
  logic [SW-1:0] sn_si;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FP_W-1:0] fetch_word(input logic [31:0] a);
    logic [FP_W-1:0] w = '0;
    for (int j = 0; j < PPF; j++)
      if (int'(a >> 1) + j < MEMP) w[j*16 +: 16] = prog[int'(a >> 1) + j];
    return w;
  endfunction

  function automatic logic [SW-1:0] exp_vec(input int p);
    logic [SW-1:0] v = '0;
    for (int k = 0; k < NS; k++) if (k < e_n[p]) v[k*32 +: 32] = e_ins[p][k];
    return v;
  endfunction

  // Program generator: packet 0 is eleven 32-bit instructions, packet 1 has
  // its eleventh parallel flag set (R6), the rest are random mixes (R2).
  task automatic build_prog();
    int pos = 0;
    for (int i = 0; i < MEMP; i++) prog[i] = '0;
    for (int p = 0; p < NPK; p++) begin
      int n = (p < 2) ? NS : 1 + int'($urandom % NS);
      e_pc[p] = 32'(pos * 2);
      e_n[p]  = n;
      for (int k = 0; k < NS; k++) e_ins[p][k] = '0;
      for (int k = 0; k < n; k++) begin
        bit wide = (p == 0) ? 1'b1 : 1'($urandom % 2);
        bit par  = (k < n - 1) || (p == 1);
        logic [15:0] lo = {16'($urandom) & 16'hFFFC} | {14'b0, par, wide};
        logic [15:0] hi = 16'($urandom);
        prog[pos] = lo;
        if (wide) begin
          prog[pos + 1] = hi;
          e_ins[p][k] = {hi, lo};
          pos += 2;
        end else begin
          e_ins[p][k] = {16'h0, lo};
          pos += 1;
        end
      end
      e_str[p] = (int'(e_pc[p] >> 1) / PPF) != ((pos - 1) / PPF);
    end
  endtask

  task automatic run_until(input int target, input int maxcyc);
    for (int c = 0; c < maxcyc && idx < target; c++) begin
      @(negedge clk);
      if (prev_flush) begin
        chk(!disp_valid && slot_valid == '0, "R9", "outputs cleared after flush",
            SW'({disp_valid, slot_valid}), '0);
        chk(fetch_addr == (flush_tgt & ~32'h3F), "R9", "fetch_addr after flush",
            SW'(fetch_addr), SW'(flush_tgt & ~32'h3F));
      end else begin
        if (prev_stall) begin
          chk(sn_dv == disp_valid && sn_pc == disp_pc && sn_sv == slot_valid &&
              sn_si == slot_inst && prev_fa == fetch_addr, "R8", "hold under stall",
              SW'({disp_valid, disp_pc, slot_valid}), SW'({sn_dv, sn_pc, sn_sv}));
        end else if (disp_valid) begin
          logic [NS-1:0] m = NS'((1 << e_n[idx]) - 1);
          chk(disp_pc == e_pc[idx], "R4", "disp_pc", SW'(disp_pc), SW'(e_pc[idx]));
          chk(slot_valid == m, (e_n[idx] == NS) ? "R6" : "R3", "slot_valid",
              SW'(slot_valid), SW'(m));
          chk(slot_inst == exp_vec(idx), e_str[idx] ? "R5" : "R2", "slot_inst",
              slot_inst, exp_vec(idx));
          idx++;
        end
        if (prev_acc)
          chk(fetch_addr == prev_fa + 32'd64, "R7", "fetch_addr step",
              SW'(fetch_addr), SW'(prev_fa + 32'd64));
        else
          chk(fetch_addr == prev_fa, "R7", "fetch_addr idle", SW'(fetch_addr), SW'(prev_fa));
      end
      sn_dv = disp_valid; sn_pc = disp_pc; sn_sv = slot_valid; sn_si = slot_inst;
      prev_fa = fetch_addr;
      stall    = ($urandom % 5) == 0;
      fp_valid = ($urandom % 7) != 0;
      fp_data  = fetch_word(fetch_addr);
      flush    = 1'b0;
      #1;
      if (stall) chk(!fetch_req, "R8", "fetch_req under stall", SW'(fetch_req), '0);
      prev_acc   = fetch_req && fp_valid;
      prev_stall = stall;
      prev_flush = 1'b0;
    end
    chk(idx >= target, "R5", "all packets dispatched", SW'(idx), SW'(target));
  endtask

  task automatic do_flush(input int m);
    @(negedge clk);
    flush_tgt = e_pc[m];
    flush     = 1'b1;
    flush_pc  = e_pc[m];
    stall     = 1'b1;   // flush must win over stall (R9)
    fp_valid  = 1'b1;
    prev_flush = 1'b1;
    prev_stall = 1'b0;
    prev_acc   = 1'b0;
    idx = m;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    build_prog();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!disp_valid && slot_valid == '0 && slot_inst == '0, "R1", "outputs in reset",
        SW'({disp_valid, slot_valid}), '0);
    chk(fetch_addr == 32'h0, "R1", "fetch_addr in reset", SW'(fetch_addr), '0);
    chk(fetch_req == 1'b1, "R1", "fetch_req in reset", SW'(fetch_req), SW'(1));
    rst = 1'b0;
    fp_data = fetch_word(32'h0);
    fp_valid = 1'b1;
    #1;
    prev_acc = fetch_req && fp_valid;
    prev_fa = fetch_addr;
    sn_dv = disp_valid; sn_pc = disp_pc; sn_sv = slot_valid; sn_si = slot_inst;
    run_until(NPK, 20000);
    // Flush into the middle of a fetch packet, then run to the end again.
    begin
      int m = NPK / 2;
      while (m < NPK - 10 && e_pc[m][5:1] == 5'd0) m++;
      do_flush(m);
      run_until(NPK, 20000);
      do_flush(7);
      run_until(40, 5000);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule